// File: doc/BRIEF.md
# Programmable Two-Rail Power Sequencer

This block drives the enable inputs of two voltage regulators. In sequenced operation a single master enable controls both rails. A rising master enable runs a power-up sequence, and a falling one runs a power-down sequence. Each sequence has up to three slots, and each slot either switches rail 1, switches rail 2, switches both rails, or idles. A programmable gap separates one slot from the next.

The power-up and power-down directions each have their own 3-bit order code and their own pair of 2-bit gap selects. A gap is a whole number of 0.5 ms ticks. An internal prescaler makes these ticks from a clock-frequency parameter. A fault input (undervoltage or over-temperature) forces the programmed power-down sequence unless a fault-ignore input is set. In direct mode (mode 0) the sequencer is bypassed and two request pins drive the rails. All configuration inputs are static levels. There is no data stream, so every pin is a plain control or status signal.

Top module: `dual_rail_sequencer`

## Requirements
- R1: While reset is asserted and after it is released, both rail enables and busy are low until a sequence or direct request changes them.
- R2: With mode_sel equal to 0, each rail enable follows its request pin one clock later, forced low while an unignored fault is present; master_en is ignored and busy stays low.
- R3: With mode_sel non-zero, a master_en transition seen at a clock edge raises busy after that edge, and the first slot acts at the following edge.
- R4: Power-up order codes (slot1, slot2, slot3): 000 = idle, rail2, rail1; 001 = rail2, rail1, idle; 010 = rail2, idle, rail1; 011 = rail1, rail2, idle; 100 = idle, rail1, rail2; 101 = rail1, idle, rail2; 110 = rail2, rail1 (two slots); 111 = both rails, idle (two slots).
- R5: Power-down order codes: 000 = idle, rail2, rail1; 001 = idle, rail1, rail2; 010 = rail1, idle, rail2; 011 = rail1, rail2, idle; 100 = rail2, rail1, idle; 101 = rail2, idle, rail1; 110 = rail1, rail2 (two slots); 111 = idle, both rails (two slots).
- R6: The gap from slot 1 to slot 2 uses the direction's first gap select, and the gap from slot 2 to slot 3 uses its second. Select values 0/1/2/3 give 1/2/4/8 ticks. Slot n+1 acts N*DIV+1 clock edges after slot n, where DIV = CLK_HZ/2000 and N is the tick count.
- R7: An idle slot leaves both rails unchanged. Busy falls right after the edge at which the last slot acts.
- R8: A master_en reversal during a sequence abandons that sequence and starts the opposite one from its first slot, with the same timing as R3. A slot that targets a rail already in the target state leaves that rail unchanged.
- R9: An unignored fault with any rail on, or during a power-up, starts the power-down sequence. While the fault is present no rail rises and a rising master_en is ignored. Clearing the fault does not restore power without a new rising master_en.
- R10: With fault_ignore high, fault_in has no effect in any mode.
- R11: In sequenced mode the rails change only at a slot's action edge. A power-up never lowers a rail and a power-down never raises one.
- R12: The prescaler tick repeats every DIV clock cycles while a gap is being timed, and restarts at the start of each gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | 0 = direct rail requests, non-zero = sequenced |
| master_en | input | 1 | Master enable for sequenced mode |
| rail1_req | input | 1 | Direct-mode request for rail 1 |
| rail2_req | input | 1 | Direct-mode request for rail 2 |
| fault_in | input | 1 | Undervoltage or over-temperature fault |
| fault_ignore | input | 1 | When high, fault_in is disregarded |
| up_order | input | 3 | Power-up order code |
| down_order | input | 3 | Power-down order code |
| up_gap1 | input | 2 | Power-up gap select, slot 1 to slot 2 |
| up_gap2 | input | 2 | Power-up gap select, slot 2 to slot 3 |
| down_gap1 | input | 2 | Power-down gap select, slot 1 to slot 2 |
| down_gap2 | input | 2 | Power-down gap select, slot 2 to slot 3 |
| rail1_en | output | 1 | Enable for regulator 1 |
| rail2_en | output | 1 | Enable for regulator 2 |
| busy | output | 1 | High while a sequence is running |

## Verification
The assertions check on every cycle that the rails hold still outside slot action edges, that a power-up never lowers a rail and a power-down never raises one, that an unignored fault never lets a rail rise, that direct mode never reports busy, and that prescaler ticks are never back to back. Only the bench scenarios can show the exact slot order for every code in both directions, the cycle-exact gap lengths for each select value, the restart behaviour when the master enable reverses, the rule that a cleared fault does not restore power, and the lack of effect of an ignored fault.

// File: rtl/drs_pkg.sv
package drs_pkg;

  typedef enum logic [2:0] {
    ACT_IDLE = 3'd0,
    ACT_R1   = 3'd1,
    ACT_R2   = 3'd2,
    ACT_BOTH = 3'd3,
    ACT_NONE = 3'd4
  } act_e;

  typedef struct packed {
    act_e s0;
    act_e s1;
    act_e s2;
  } plan_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EXEC = 2'd1,
    ST_GAP  = 2'd2
  } seq_state_e;

  function automatic plan_t up_plan(input logic [2:0] code);
    plan_t p;
    case (code)
      3'b000:  p = '{ACT_IDLE, ACT_R2,   ACT_R1};
      3'b001:  p = '{ACT_R2,   ACT_R1,   ACT_IDLE};
      3'b010:  p = '{ACT_R2,   ACT_IDLE, ACT_R1};
      3'b011:  p = '{ACT_R1,   ACT_R2,   ACT_IDLE};
      3'b100:  p = '{ACT_IDLE, ACT_R1,   ACT_R2};
      3'b101:  p = '{ACT_R1,   ACT_IDLE, ACT_R2};
      3'b110:  p = '{ACT_R2,   ACT_R1,   ACT_NONE};
      default: p = '{ACT_BOTH, ACT_IDLE, ACT_NONE};
    endcase
    return p;
  endfunction

  function automatic plan_t down_plan(input logic [2:0] code);
    plan_t p;
    case (code)
      3'b000:  p = '{ACT_IDLE, ACT_R2,   ACT_R1};
      3'b001:  p = '{ACT_IDLE, ACT_R1,   ACT_R2};
      3'b010:  p = '{ACT_R1,   ACT_IDLE, ACT_R2};
      3'b011:  p = '{ACT_R1,   ACT_R2,   ACT_IDLE};
      3'b100:  p = '{ACT_R2,   ACT_R1,   ACT_IDLE};
      3'b101:  p = '{ACT_R2,   ACT_IDLE, ACT_R1};
      3'b110:  p = '{ACT_R1,   ACT_R2,   ACT_NONE};
      default: p = '{ACT_IDLE, ACT_BOTH, ACT_NONE};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/drs_tick_gen.sv
module drs_tick_gen #(
  parameter int DIV = 25000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R12

endmodule

// File: rtl/drs_gap_timer.sv
module drs_gap_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic         expire
);
  logic [W-1:0] rem_q;

  assign expire = tick && (rem_q == W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) rem_q <= '0;
    else if (load) rem_q <= load_val;
    else if (tick && rem_q != '0) rem_q <= rem_q - 1'b1;
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load) |-> (rem_q != '0)); // R6

endmodule

// File: rtl/drs_order_decode.sv
module drs_order_decode
  import drs_pkg::*;
#(
  parameter bit IS_DOWN = 1'b0
) (
  input  logic [2:0] code,
  output plan_t      plan
);
  generate
    if (IS_DOWN) begin : g_down
      always_comb plan = down_plan(code);
    end else begin : g_up
      always_comb plan = up_plan(code);
    end
  endgenerate
endmodule

// File: rtl/dual_rail_sequencer.sv
module dual_rail_sequencer
  import drs_pkg::*;
#(
  parameter int CLK_HZ    = 50_000_000,
  parameter int TICK_HZ   = 2000,
  parameter int MAX_TICKS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  input  logic       master_en,
  input  logic       rail1_req,
  input  logic       rail2_req,
  input  logic       fault_in,
  input  logic       fault_ignore,
  input  logic [2:0] up_order,
  input  logic [2:0] down_order,
  input  logic [1:0] up_gap1,
  input  logic [1:0] up_gap2,
  input  logic [1:0] down_gap1,
  input  logic [1:0] down_gap2,
  output logic       rail1_en,
  output logic       rail2_en,
  output logic       busy
);
  localparam int DIV   = CLK_HZ / TICK_HZ;
  localparam int GAP_W = $clog2(MAX_TICKS + 1);

  seq_state_e state_q;
  logic       dir_up_q;
  logic [1:0] idx_q;
  logic       r1_q, r2_q;
  logic       men_q;

  plan_t up_p, dn_p, cur_p;
  act_e  cur_act;
  logic  seq_mode, flt_act, men_rise, men_fall, running;
  logic  want_down, start_down, start_up, last_slot;
  logic  hit_r1, hit_r2;
  logic [1:0]       gap_sel;
  logic [GAP_W-1:0] gap_ticks;
  logic  tick, expire, tmr_load;

  drs_order_decode #(.IS_DOWN(1'b0)) u_up_dec (.code(up_order),   .plan(up_p));
  drs_order_decode #(.IS_DOWN(1'b1)) u_dn_dec (.code(down_order), .plan(dn_p));

  assign seq_mode = (mode_sel != 2'b00);
  assign flt_act  = fault_in && !fault_ignore;
  assign men_rise = master_en && !men_q;
  assign men_fall = !master_en && men_q;
  assign running  = (state_q != ST_IDLE);

  assign cur_p = dir_up_q ? up_p : dn_p;

  always_comb begin
    case (idx_q)
      2'd0:    cur_act = cur_p.s0;
      2'd1:    cur_act = cur_p.s1;
      default: cur_act = cur_p.s2;
    endcase
  end

  assign last_slot = (idx_q == 2'd2) || (idx_q == 2'd1 && cur_p.s2 == ACT_NONE);
  assign hit_r1    = (cur_act == ACT_R1) || (cur_act == ACT_BOTH);
  assign hit_r2    = (cur_act == ACT_R2) || (cur_act == ACT_BOTH);

  // Power-down has priority; a running sequence in the same direction is kept
  assign want_down  = men_fall || (flt_act && (running ? dir_up_q : (r1_q || r2_q)));
  assign start_down = seq_mode && want_down && !(running && !dir_up_q);
  assign start_up   = seq_mode && !start_down && men_rise && !flt_act
                      && !(running && dir_up_q);

  always_comb begin
    if (idx_q == 2'd0) gap_sel = dir_up_q ? up_gap1 : down_gap1;
    else               gap_sel = dir_up_q ? up_gap2 : down_gap2;
  end
  assign gap_ticks = GAP_W'(1) << gap_sel;
  assign tmr_load  = seq_mode && (state_q == ST_EXEC) && !last_slot
                     && !start_down && !start_up;

  drs_tick_gen #(.DIV(DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (state_q == ST_GAP),
    .tick (tick)
  );

  drs_gap_timer #(.W(GAP_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(gap_ticks),
    .tick    (tick),
    .expire  (expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) men_q <= 1'b0;
    else        men_q <= master_en;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      dir_up_q <= 1'b0;
      idx_q    <= 2'd0;
      r1_q     <= 1'b0;
      r2_q     <= 1'b0;
    end else if (!seq_mode) begin
      state_q <= ST_IDLE;
      idx_q   <= 2'd0;
      r1_q    <= rail1_req && !flt_act;
      r2_q    <= rail2_req && !flt_act;
    end else if (start_down || start_up) begin
      state_q  <= ST_EXEC;
      dir_up_q <= start_up;
      idx_q    <= 2'd0;
    end else begin
      case (state_q)
        ST_EXEC: begin
          if (hit_r1) r1_q <= dir_up_q;
          if (hit_r2) r2_q <= dir_up_q;
          state_q <= last_slot ? ST_IDLE : ST_GAP;
        end
        ST_GAP: begin
          if (expire) begin
            state_q <= ST_EXEC;
            idx_q   <= idx_q + 2'd1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rail1_en = r1_q;
  assign rail2_en = r2_q;
  assign busy     = running;

  AST_GAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_mode && state_q != ST_EXEC) |=> $stable({rail1_en, rail2_en})); // R11

  AST_UP_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_mode && running && dir_up_q) |=> (!$fell(rail1_en) && !$fell(rail2_en))); // R11

  AST_DOWN_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_mode && running && !dir_up_q) |=> (!$rose(rail1_en) && !$rose(rail2_en))); // R11

  AST_FAULT_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_mode && flt_act) |=> (!$rose(rail1_en) && !$rose(rail2_en))); // R9

  AST_DIRECT_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_mode) |=> !busy); // R2

endmodule

// File: tb/dual_rail_sequencer_tb_top.sv
module dual_rail_sequencer_tb_top;
  localparam int TB_CLK_HZ = 8000;
  localparam int DIV       = TB_CLK_HZ / 2000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode_sel = 2'd0;
  logic master_en = 1'b0, rail1_req = 1'b0, rail2_req = 1'b0;
  logic fault_in = 1'b0, fault_ignore = 1'b0;
  logic [2:0] up_order = 3'd0, down_order = 3'd0;
  logic [1:0] up_gap1 = 2'd0, up_gap2 = 2'd0, down_gap1 = 2'd0, down_gap2 = 2'd0;
  logic rail1_en, rail2_en, busy;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int e1 = 0, e2 = 0;

  always #10 clk = ~clk;

  dual_rail_sequencer #(.CLK_HZ(TB_CLK_HZ)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .master_en(master_en),
    .rail1_req(rail1_req), .rail2_req(rail2_req), .fault_in(fault_in),
    .fault_ignore(fault_ignore), .up_order(up_order), .down_order(down_order),
    .up_gap1(up_gap1), .up_gap2(up_gap2), .down_gap1(down_gap1), .down_gap2(down_gap2),
    .rail1_en(rail1_en), .rail2_en(rail2_en), .busy(busy)
  );

  // {up_order, down_order, up_gap1, up_gap2, down_gap1, down_gap2}
  localparam logic [13:0] VECS [0:7] = '{
    {3'b000, 3'b111, 2'd0, 2'd1, 2'd2, 2'd0},
    {3'b001, 3'b110, 2'd1, 2'd0, 2'd0, 2'd1},
    {3'b010, 3'b101, 2'd0, 2'd2, 2'd1, 2'd0},
    {3'b011, 3'b100, 2'd3, 2'd0, 2'd0, 2'd0},
    {3'b100, 3'b011, 2'd0, 2'd0, 2'd0, 2'd3},
    {3'b101, 3'b010, 2'd1, 2'd1, 2'd2, 2'd1},
    {3'b110, 3'b001, 2'd2, 2'd3, 2'd1, 2'd0},
    {3'b111, 3'b000, 2'd1, 2'd0, 2'd0, 2'd2}
  };

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic chk_rails(input string tag);
    chk(tag, "rail1_en", int'(rail1_en), e1);
    chk(tag, "rail2_en", int'(rail2_en), e2);
  endtask

  // slot codes: 0 idle, 1 rail1, 2 rail2, 3 both, 4 no slot
  function automatic int bplan(input bit up, input logic [2:0] code);
    if (up) begin
      case (code)
        3'b000: return 'h021; 3'b001: return 'h210;
        3'b010: return 'h201; 3'b011: return 'h120;
        3'b100: return 'h012; 3'b101: return 'h102;
        3'b110: return 'h214; default: return 'h304;
      endcase
    end else begin
      case (code)
        3'b000: return 'h021; 3'b001: return 'h012;
        3'b010: return 'h102; 3'b011: return 'h120;
        3'b100: return 'h210; 3'b101: return 'h201;
        3'b110: return 'h124; default: return 'h034;
      endcase
    end
  endfunction

  task automatic apply_act(input bit up, input int a);
    if (a == 1 || a == 3) e1 = up ? 1 : 0;
    if (a == 2 || a == 3) e2 = up ? 1 : 0;
  endtask

  // Called right after the negedge at which the start condition was driven
  task automatic follow(input bit up);
    int p;
    int a;
    string tag;
    tag = up ? "R4" : "R5";
    p = bplan(up, up ? up_order : down_order);
    @(negedge clk);
    chk("R3", "busy at start", int'(busy), 1);
    chk_rails("R3");
    @(negedge clk);
    a = (p >> 8) & 'hf;
    apply_act(up, a);
    chk_rails(tag);
    for (int i = 1; i < 3; i++) begin
      int n;
      logic [1:0] sel;
      a = (p >> (4 * (2 - i))) & 'hf;
      if (a == 4) break;
      if (i == 1) sel = up ? up_gap1 : down_gap1;
      else        sel = up ? up_gap2 : down_gap2;
      n = 1 << sel;
      repeat (n * DIV) @(negedge clk);
      chk("R6", "busy in gap", int'(busy), 1);
      chk_rails("R11 R12 gap hold");
      @(negedge clk);
      apply_act(up, a);
      chk_rails(a == 0 ? "R7" : tag);
    end
    chk("R7", "busy after last slot", int'(busy), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", int'(busy), 0);
    chk_rails("R1");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "busy after reset", int'(busy), 0);
    chk_rails("R1");

    // Direct mode
    rail1_req = 1'b1;
    @(negedge clk);
    e1 = 1; e2 = 0;
    chk_rails("R2");
    master_en = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2", "busy in direct mode", int'(busy), 0);
    chk_rails("R2");
    fault_in = 1'b1;
    @(negedge clk);
    e1 = 0;
    chk_rails("R2 fault gate");
    fault_ignore = 1'b1;
    @(negedge clk);
    e1 = 1;
    chk_rails("R10 direct");
    fault_in = 1'b0; fault_ignore = 1'b0;
    rail1_req = 1'b0; master_en = 1'b0;
    repeat (2) @(negedge clk);
    e1 = 0; e2 = 0;
    chk_rails("R2");

    // Sequenced mode: table walk
    mode_sel = 2'd2;
    @(negedge clk);
    for (int v = 0; v < 8; v++) begin
      {up_order, down_order, up_gap1, up_gap2, down_gap1, down_gap2} = VECS[v];
      master_en = 1'b1;
      follow(1'b1);
      repeat (3) @(negedge clk);
      master_en = 1'b0;
      follow(1'b0);
      repeat (3) @(negedge clk);
    end

    // R8 reversal mid power-up
    up_order = 3'b011; up_gap1 = 2'd1; up_gap2 = 2'd0;
    down_order = 3'b110; down_gap1 = 2'd0; down_gap2 = 2'd0;
    master_en = 1'b1;
    @(negedge clk);
    @(negedge clk);
    e1 = 1;
    chk_rails("R8 first slot");
    repeat (3) @(negedge clk);
    master_en = 1'b0;
    follow(1'b0);
    chk_rails("R8 after reversal");

    // R9 fault shutdown
    up_order = 3'b111; down_order = 3'b011; down_gap1 = 2'd1; down_gap2 = 2'd0;
    master_en = 1'b1;
    follow(1'b1);
    repeat (2) @(negedge clk);
    fault_in = 1'b1;
    follow(1'b0);
    fault_in = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9", "busy after fault cleared", int'(busy), 0);
    chk_rails("R9 no re-power");
    master_en = 1'b0;
    follow(1'b0);
    fault_in = 1'b1;
    master_en = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9", "busy with rise during fault", int'(busy), 0);
    chk_rails("R9 rise blocked");
    fault_in = 1'b0;
    master_en = 1'b0;
    repeat (3) @(negedge clk);

    // R10 ignored fault
    fault_ignore = 1'b1;
    master_en = 1'b1;
    follow(1'b1);
    fault_in = 1'b1;
    repeat (10) @(negedge clk);
    chk("R10", "busy with ignored fault", int'(busy), 0);
    chk_rails("R10 rails kept");
    master_en = 1'b0;
    follow(1'b0);
    fault_in = 1'b0;
    fault_ignore = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule